// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. It takes the accumulator, a second operand, a 5-bit operation code and the current status flags. When `go_i` is high it latches a result, an accumulator write-enable and the new flags. All three appear on the outputs one clock later, with `done_o` high for that one cycle. The status word holds sign, zero, auxiliary carry, parity and carry.

Each operation has its own rule for which flags it changes. Add, subtract and compare compute the full flag set. Compare does not write the accumulator. Byte increment and decrement keep the incoming carry. Rotates and the carry operations change only the carry. Complementing the accumulator changes no flag. Decoding instructions and fetching operands are done outside the block.

The control is a single registered stage. There are two named conditions: IDLE, where `go_i` is low and the outputs hold, and ISSUE, where `go_i` is high and the outputs are reloaded on the next edge. Every transition between them is taken on the clock edge that samples `go_i`.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `res_o`, `flags_o`, `acc_we_o` and `done_o` are all 0.
- R2: If `go_i` is high at a rising edge, that edge loads the outputs and `done_o` is 1 in the following cycle. Operation codes: 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 AND, 5 OR, 6 XOR, 7 CMP, 8 INC, 9 DEC, 10 CMA, 11 STC, 12 CMC, 13 RLC, 14 RRC, 15 RAL, 16 RAR.
- R3: ADD gives A+B and ignores the incoming carry. ADC gives A+B+CY. CY is the carry out of bit 7 and the accumulator is written.
- R4: SUB gives A−B and SBB gives A−B−CY. CY is 1 when a borrow out of bit 7 occurs and AC is 1 on a borrow from bit 3.
- R5: CMP sets the flags exactly as SUB would. It does not write the accumulator and presents the unchanged A on `res_o`.
- R6: AND, OR and XOR write the result, set S, Z and P from the result, and clear AC and CY.
- R7: INC and DEC add or subtract 1. They update S, Z, AC and P, and CY keeps its incoming value.
- R8: RLC and RRC rotate A by one bit within 8 bits, and the bit shifted out is copied to CY.
- R9: RAL and RAR rotate through a 9-bit ring formed by A and CY.
- R10: CMA writes the inverse of A and leaves all flags unchanged. STC sets CY and CMC inverts CY, and neither writes the accumulator.
- R11: `flags_o` is packed as {S,Z,AC,P,CY} in bits 4..0. S is result bit 7, Z is 1 for a zero result, and P is 1 for an even count of set bits. The rotates and the carry operations keep S, Z, AC and P.
- R12: While `go_i` is low, `done_o` and `acc_we_o` read 0 and `res_o` and `flags_o` hold their last values.
- R13: Operation codes 17 to 31 do not write the accumulator. They pass `acc_i` and `flags_i` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Issue the operation this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 5 | Current flags {S,Z,AC,P,CY} |
| res_o | output | 8 | Result value |
| acc_we_o | output | 1 | Accumulator write-enable |
| flags_o | output | 5 | New flags {S,Z,AC,P,CY} |
| done_o | output | 1 | Result valid for one cycle |

## Verification
The bench targets the places where flag rules diverge:
- It uses 3A+C6, which wraps to zero and carries out of both the low nibble and bit 7. A design with a wrong carry chain misses Z, AC or CY here.
- It runs ADD with carry set. A design that does not separate ADD from ADC reports 03 instead of 02.
- It runs INC of FF and DEC of 00 with opposite incoming carries. These expose a design that lets the carry out of the increment leak into CY.
- It runs the rotates with bit 0 or bit 7 set, and with the other flags set to 1. These catch a design that mixes up the rotate-with-carry and rotate-through-carry forms, or that clears the untouched flags.
- It checks compare and STC for a spurious accumulator write.
- It checks that an unused operation code passes everything through.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_AND = 5'd4,
        OP_OR  = 5'd5,
        OP_XOR = 5'd6,
        OP_CMP = 5'd7,
        OP_INC = 5'd8,
        OP_DEC = 5'd9,
        OP_CMA = 5'd10,
        OP_STC = 5'd11,
        OP_CMC = 5'd12,
        OP_RLC = 5'd13,
        OP_RRC = 5'd14,
        OP_RAL = 5'd15,
        OP_RAR = 5'd16
    } alu_op_e;

    // bit 4..0 = sign, zero, aux carry, parity, carry
    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } alu_flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output alu_flags_t   fl
);
    localparam int NIB = 4;

    logic [W-1:0]   opnd;
    logic           ci;
    logic           sub;
    logic [W:0]     wide;
    logic [NIB:0]   nib;

    always_comb begin
        opnd = b;
        ci   = 1'b0;
        sub  = 1'b0;
        unique case (op)
            OP_ADC:         ci = cin;
            OP_SUB, OP_CMP: sub = 1'b1;
            OP_SBB: begin
                sub = 1'b1;
                ci  = cin;
            end
            OP_INC:         opnd = W'(1);
            OP_DEC: begin
                opnd = W'(1);
                sub  = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (sub) begin
            wide = {1'b0, a} - {1'b0, opnd} - {{W{1'b0}}, ci};
            nib  = {1'b0, a[NIB-1:0]} - {1'b0, opnd[NIB-1:0]} - {{NIB{1'b0}}, ci};
        end else begin
            wide = {1'b0, a} + {1'b0, opnd} + {{W{1'b0}}, ci};
            nib  = {1'b0, a[NIB-1:0]} + {1'b0, opnd[NIB-1:0]} + {{NIB{1'b0}}, ci};
        end
    end

    always_comb begin
        res   = wide[W-1:0];
        fl.s  = wide[W-1];
        fl.z  = (wide[W-1:0] == '0);
        fl.ac = nib[NIB];
        fl.p  = ~^wide[W-1:0];
        fl.cy = (op == OP_INC || op == OP_DEC) ? cin : wide[W];
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output alu_flags_t   fl
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = ~a;
        endcase
    end

    always_comb begin
        fl.s  = res[W-1];
        fl.z  = (res == '0);
        fl.ac = 1'b0;
        fl.p  = ~^res;
        fl.cy = 1'b0;
    end

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cy
);
    always_comb begin
        res = a;
        cy  = cin;
        unique case (op)
            OP_RLC: begin
                res = {a[W-2:0], a[W-1]};
                cy  = a[W-1];
            end
            OP_RRC: begin
                res = {a[0], a[W-1:1]};
                cy  = a[0];
            end
            OP_RAL: begin
                res = {a[W-2:0], cin};
                cy  = a[W-1];
            end
            OP_RAR: begin
                res = {cin, a[W-1:1]};
                cy  = a[0];
            end
            OP_STC:  cy = 1'b1;
            OP_CMC:  cy = ~cin;
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      acc_i,
    input  logic [W-1:0]      opnd_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      res_o,
    output logic              acc_we_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              done_o
);
    typedef enum logic {ST_IDLE, ST_ISSUE} st_e;

    alu_op_e    op;
    alu_flags_t fin;
    st_e        st_nxt;

    logic [W-1:0] ar_res, lg_res, rt_res;
    alu_flags_t   ar_fl, lg_fl;
    logic         rt_cy;

    logic [W-1:0] nxt_res;
    alu_flags_t   nxt_fl;
    logic         nxt_we;

    logic [W-1:0] res_q;
    alu_flags_t   fl_q;
    logic         we_q;
    logic         done_q;

    assign op  = alu_op_e'(op_i);
    assign fin = alu_flags_t'(flags_i);

    alu8_arith #(.W(W)) u_arith (
        .op  (op),
        .a   (acc_i),
        .b   (opnd_i),
        .cin (fin.cy),
        .res (ar_res),
        .fl  (ar_fl)
    );

    alu8_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (acc_i),
        .b   (opnd_i),
        .res (lg_res),
        .fl  (lg_fl)
    );

    alu8_rotate #(.W(W)) u_rot (
        .op  (op),
        .a   (acc_i),
        .cin (fin.cy),
        .res (rt_res),
        .cy  (rt_cy)
    );

    // result / flag / write selection per operation
    always_comb begin
        nxt_res = acc_i;
        nxt_fl  = fin;
        nxt_we  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC: begin
                nxt_res = ar_res;
                nxt_fl  = ar_fl;
                nxt_we  = 1'b1;
            end
            OP_CMP: begin
                nxt_fl  = ar_fl;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_res = lg_res;
                nxt_fl  = lg_fl;
                nxt_we  = 1'b1;
            end
            OP_CMA: begin
                nxt_res = lg_res;
                nxt_we  = 1'b1;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                nxt_res   = rt_res;
                nxt_fl.cy = rt_cy;
                nxt_we    = 1'b1;
            end
            OP_STC, OP_CMC: begin
                nxt_fl.cy = rt_cy;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_nxt = go_i ? ST_ISSUE : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            fl_q   <= '0;
            we_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            unique case (st_nxt)
                ST_ISSUE: begin
                    res_q  <= nxt_res;
                    fl_q   <= nxt_fl;
                    we_q   <= nxt_we;
                    done_q <= 1'b1;
                end
                ST_IDLE: begin
                    we_q   <= 1'b0;
                    done_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign res_o    = res_q;
    assign flags_o  = fl_q;
    assign acc_we_o = we_q;
    assign done_o   = done_q;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              go_i,
    input logic [OP_W-1:0]   op_i,
    input logic [W-1:0]      acc_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [W-1:0]      res_o,
    input logic              acc_we_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              done_o
);
    a_r2_done_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> done_o);

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> (!done_o && !acc_we_o && $stable(res_o) && $stable(flags_o)));

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && op_i == OP_CMP) |=> (!acc_we_o && res_o == $past(acc_i)));

    a_r7_incdec_keep_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[0] == $past(flags_i[0])));

    a_r11_rot_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && op_i >= OP_RLC && op_i <= OP_RAR) |=> (flags_o[4:1] == $past(flags_i[4:1])));

    a_r10_stc_sets_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && op_i == OP_STC) |=> (flags_o[0] && !acc_we_o));

    a_r6_logic_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && op_i >= OP_AND && op_i <= OP_XOR) |=> (flags_o[3] == (res_o == '0) && flags_o[0] == 1'b0));

    a_r13_unused_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && op_i > OP_RAR) |=> (!acc_we_o && flags_o == $past(flags_i)));

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (go_i),
    .op_i     (op_i),
    .acc_i    (acc_i),
    .flags_i  (flags_i),
    .res_o    (res_o),
    .acc_we_o (acc_we_o),
    .flags_o  (flags_o),
    .done_o   (done_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [4:0] flags_i = '0;
    logic [7:0] res_o;
    logic       acc_we_o;
    logic [4:0] flags_o;
    logic       done_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    alu8_core u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go_i),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .flags_i  (flags_i),
        .res_o    (res_o),
        .acc_we_o (acc_we_o),
        .flags_o  (flags_o),
        .done_o   (done_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic [4:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [4:0] fi,
                         input logic [7:0] e_res, input logic e_we, input logic [4:0] e_fl);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; flags_i = fi; go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        chk({req, " result"}, {8'h0, res_o}, {8'h0, e_res});
        chk({req, " write"}, {15'h0, acc_we_o}, {15'h0, e_we});
        chk({req, " flags"}, {11'h0, flags_o}, {11'h0, e_fl});
        chk({req, " done"}, {15'h0, done_o}, 16'h1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset res", {8'h0, res_o}, 16'h0);
        chk("R1 reset flags", {11'h0, flags_o}, 16'h0);
        chk("R1 reset we/done", {14'h0, acc_we_o, done_o}, 16'h0);
    endtask

    task automatic t_add();
        issue("R3 ADD wrap, R11 flags", 5'd0, 8'h3A, 8'hC6, 5'h00, 8'h00, 1'b1, 5'h0F);
        issue("R3 ADD ignores CY", 5'd0, 8'h01, 8'h01, 5'h01, 8'h02, 1'b1, 5'h00);
        issue("R3 ADC uses CY", 5'd1, 8'h01, 8'h01, 5'h01, 8'h03, 1'b1, 5'h02);
    endtask

    task automatic t_sub();
        issue("R4 SUB borrow", 5'd2, 8'h05, 8'h07, 5'h00, 8'hFE, 1'b1, 5'h15);
        issue("R4 SBB to zero", 5'd3, 8'h10, 8'h0F, 5'h01, 8'h00, 1'b1, 5'h0E);
    endtask

    task automatic t_cmp();
        issue("R5 CMP equal", 5'd7, 8'h20, 8'h20, 5'h01, 8'h20, 1'b0, 5'h0A);
        issue("R5 CMP less", 5'd7, 8'h10, 8'h20, 5'h00, 8'h10, 1'b0, 5'h13);
    endtask

    task automatic t_logic();
        issue("R6 AND clears CY", 5'd4, 8'hF0, 8'h3C, 5'h05, 8'h30, 1'b1, 5'h02);
        issue("R6 OR", 5'd5, 8'h80, 8'h01, 5'h00, 8'h81, 1'b1, 5'h12);
        issue("R6 XOR zero", 5'd6, 8'h55, 8'h55, 5'h01, 8'h00, 1'b1, 5'h0A);
    endtask

    task automatic t_incdec();
        issue("R7 INC FF keeps CY=0", 5'd8, 8'hFF, 8'h00, 5'h00, 8'h00, 1'b1, 5'h0E);
        issue("R7 INC 0F keeps CY=1", 5'd8, 8'h0F, 8'h00, 5'h01, 8'h10, 1'b1, 5'h05);
        issue("R7 DEC 00 keeps CY=1", 5'd9, 8'h00, 8'h00, 5'h01, 8'hFF, 1'b1, 5'h17);
    endtask

    task automatic t_rot();
        issue("R8 RLC", 5'd13, 8'h81, 8'h00, 5'h1E, 8'h03, 1'b1, 5'h1F);
        issue("R8 RRC", 5'd14, 8'h01, 8'h00, 5'h1E, 8'h80, 1'b1, 5'h1F);
        issue("R9 RAL out", 5'd15, 8'h80, 8'h00, 5'h1E, 8'h00, 1'b1, 5'h1F);
        issue("R9 RAL in", 5'd15, 8'h01, 8'h00, 5'h1F, 8'h03, 1'b1, 5'h1E);
        issue("R9 RAR in", 5'd16, 8'h02, 8'h00, 5'h1F, 8'h81, 1'b1, 5'h1E);
    endtask

    task automatic t_carry();
        issue("R10 CMA", 5'd10, 8'h5A, 8'h00, 5'h0B, 8'hA5, 1'b1, 5'h0B);
        issue("R10 STC", 5'd11, 8'h44, 8'h00, 5'h00, 8'h44, 1'b0, 5'h01);
        issue("R10 CMC set", 5'd12, 8'h44, 8'h00, 5'h1E, 8'h44, 1'b0, 5'h1F);
        issue("R10 CMC clear", 5'd12, 8'h44, 8'h00, 5'h01, 8'h44, 1'b0, 5'h00);
    endtask

    task automatic t_unused();
        issue("R13 unused code", 5'd31, 8'h77, 8'h12, 5'h15, 8'h77, 1'b0, 5'h15);
    endtask

    task automatic t_idle();
        issue("R2 issue before idle", 5'd0, 8'h10, 8'h22, 5'h00, 8'h32, 1'b1, 5'h00);
        @(negedge clk);
        op_i = 5'd2; acc_i = 8'hFF; opnd_i = 8'h01; flags_i = 5'h1F;
        @(negedge clk);
        chk("R12 idle done/we", {14'h0, done_o, acc_we_o}, 16'h0);
        chk("R12 idle res held", {8'h0, res_o}, 16'h0032);
        chk("R12 idle flags held", {11'h0, flags_o}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_incdec();
        t_rot();
        t_carry();
        t_unused();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule